// File: doc/BRIEF.md
# Multi-Sequence Priority Program Counter

This block holds one program counter per device sequence and decides, one instruction at a time, which sequence supplies the next fetch address. Every device owns a sequence at a fixed priority. A lower sequence index means a higher priority. The highest index is a background sequence that is always pending. When a device raises its request line, the request is latched. The running program is only preempted at instructions that software has marked with a break bit. An instruction carrying a dismiss bit retires the running sequence's request and hands control to the best remaining pending sequence, which may have a lower priority.

The surrounding core reports each completed instruction with a step strobe and the two control bits of that instruction. The block answers with a registered fetch address and the index of the sequence now running. A preempted sequence keeps the address of its next instruction, and resumes from there when it is selected again. A write port loads any counter, for example at start-up.

Top module: `mseq_pc_sched`

## Requirements
- R1: After a synchronous reset, `cur_seq` equals NUM_SEQ-1 (the background sequence), `fetch_addr` is 0, and only the background sequence is pending.
- R2: A request for sequence i (i < NUM_SEQ-1) is latched when `dev_req[i]` is high at a clock edge after being low at the previous edge, and stays latched until that sequence is dismissed; `dev_req[NUM_SEQ-1]` has no effect, and the background sequence is never dismissed.
- R3: A step with neither break nor dismiss keeps `cur_seq` unchanged and makes `fetch_addr` one higher in the next cycle; without a step both outputs hold.
- R4: A step with the break bit (and no dismiss) selects the lowest-index pending sequence; if that is another sequence, `fetch_addr` becomes its stored counter value in the next cycle.
- R5: A pending higher-priority sequence never takes over on a step without break or dismiss.
- R6: A step with the dismiss bit (with or without break) clears the running sequence's latched request and selects the lowest-index sequence still pending, even if it has a lower priority than the one just dismissed.
- R7: A sequence that is switched away from stores the address after its last stepped instruction, and `fetch_addr` shows that address when it is selected again.
- R8: With `wr_en` high, counter `wr_sel` is loaded with `wr_data`; when `wr_sel` is the running sequence, `fetch_addr` shows `wr_data` in the next cycle, overriding the increment of a simultaneous step.
- R9: A new rising request of the running sequence in the same cycle as its dismiss keeps the request latched, so the sequence remains selectable in that same selection.
- R10: A request whose rising edge falls in the cycle of a break or dismiss step takes part in that step's selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NUM_SEQ | Request lines, one per sequence; bit 0 has the highest priority |
| step | input | 1 | One instruction of the running sequence has completed |
| step_brk | input | 1 | Break bit of the completed instruction |
| step_dsm | input | 1 | Dismiss bit of the completed instruction |
| wr_en | input | 1 | Load a counter |
| wr_sel | input | IDX_W | Index of the counter to load |
| wr_data | input | ADDR_W | Value to load |
| cur_seq | output | IDX_W | Index of the running sequence (registered) |
| fetch_addr | output | ADDR_W | Next fetch address (registered) |

## Verification
A dismiss of the running sequence and a fresh rising request from that same sequence's device can land on one clock edge, and so can a counter load and a step of the sequence it targets. The bench provokes both: it pulses the running sequence's request line in the dismiss cycle and expects that sequence to stay selected with its address advanced by one, and it loads the running counter during a step and expects the loaded value, not the increment. A reference model in the bench predicts the index and address for every cycle and a monitor compares them one cycle after each edge.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  // What a completed instruction asks the selector to do.
  typedef enum logic [1:0] {
    SEL_KEEP    = 2'd0,
    SEL_PREEMPT = 2'd1,
    SEL_RETIRE  = 2'd2
  } sel_kind_e;

  typedef struct packed {
    logic valid;
    logic brk;
    logic dsm;
  } step_t;

  function automatic sel_kind_e classify(input step_t s);
    if (!s.valid)    return SEL_KEEP;
    else if (s.dsm)  return SEL_RETIRE;
    else if (s.brk)  return SEL_PREEMPT;
    else             return SEL_KEEP;
  endfunction

endpackage

// File: rtl/mseq_req_latch.sv
module mseq_req_latch #(
  parameter int NUM_SEQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SEQ-1:0] dev_req_i,
  input  logic [NUM_SEQ-1:0] clr_i,
  output logic [NUM_SEQ-1:0] req_o,
  output logic [NUM_SEQ-1:0] req_nxt_o
);

  localparam int BG = NUM_SEQ - 1;

  for (genvar gi = 0; gi < NUM_SEQ; gi++) begin : g_cell
    if (gi == BG) begin : g_background
      // Background sequence: permanently pending, its line and clear are don't-care.
      assign req_nxt_o[gi] = 1'b1 | (dev_req_i[gi] & ~clr_i[gi]);
      assign req_o[gi]     = 1'b1;
    end else begin : g_device
      logic prev_q;
      logic held_q;
      logic rise;

      assign rise          = dev_req_i[gi] & ~prev_q;
      // A new edge wins over a clear in the same cycle.
      assign req_nxt_o[gi] = (held_q & ~clr_i[gi]) | rise;
      assign req_o[gi]     = held_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q <= 1'b0;
          held_q <= 1'b0;
        end else begin
          prev_q <= dev_req_i[gi];
          held_q <= req_nxt_o[gi];
        end
      end
    end
  end

endmodule

// File: rtl/mseq_prio_sel.sv
module mseq_prio_sel #(
  parameter int NUM_SEQ = 32,
  parameter int IDX_W   = $clog2(NUM_SEQ)
) (
  input  logic [NUM_SEQ-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);

  // Ripple "already taken" chain: grant goes to the lowest set index.
  logic [NUM_SEQ:0]   taken;
  logic [NUM_SEQ-1:0] grant;
  logic [IDX_W-1:0]   part [NUM_SEQ+1];

  assign taken[0] = 1'b0;
  assign part[0]  = '0;

  for (genvar gi = 0; gi < NUM_SEQ; gi++) begin : g_chain
    assign grant[gi]    = req_i[gi] & ~taken[gi];
    assign taken[gi+1]  = taken[gi] | req_i[gi];
    assign part[gi+1]   = part[gi] | (grant[gi] ? IDX_W'(gi) : '0);
  end

  assign any_o = taken[NUM_SEQ];
  assign idx_o = part[NUM_SEQ];

endmodule

// File: rtl/mseq_pc_bank.sv
module mseq_pc_bank #(
  parameter int NUM_SEQ = 32,
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = $clog2(NUM_SEQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  cur_i,
  input  logic [IDX_W-1:0]  nxt_i,
  input  logic              step_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] fetch_o
);

  // Saved counters of the sequences that are not running.
  logic [ADDR_W-1:0] mem [NUM_SEQ];
  logic [ADDR_W-1:0] fetch_q;
  logic [ADDR_W-1:0] live;
  logic [ADDR_W-1:0] resume;
  logic              sw;
  logic              wr_cur;
  logic              wr_nxt;

  assign sw     = (nxt_i != cur_i);
  assign wr_cur = wr_en_i && (wr_idx_i == cur_i);
  assign wr_nxt = wr_en_i && (wr_idx_i == nxt_i);

  // Running counter after this cycle: a load overrides the increment.
  always_comb begin
    if (wr_cur)      live = wr_data_i;
    else if (step_i) live = fetch_q + ADDR_W'(1);
    else             live = fetch_q;
  end

  assign resume = wr_nxt ? wr_data_i : mem[nxt_i];

  always_ff @(posedge clk) begin
    if (rst) fetch_q <= '0;
    else     fetch_q <= sw ? resume : live;
  end

  // Storage without reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (!rst) begin
      if (wr_en_i && !wr_cur) mem[wr_idx_i] <= wr_data_i;
      if (sw)                 mem[cur_i]    <= live;
    end
  end

  assign fetch_o = fetch_q;

  // R3: a plain step of the running sequence advances its address by one.
  p_step_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !sw && !wr_cur) |=> (fetch_q == $past(fetch_q) + ADDR_W'(1)));

  // R8: loading the running counter shows the loaded value next cycle.
  p_load_live_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_cur && !sw) |=> (fetch_q == $past(wr_data_i)));

endmodule

// File: rtl/mseq_pc_sched.sv
module mseq_pc_sched #(
  parameter int NUM_SEQ = 32,
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = $clog2(NUM_SEQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SEQ-1:0] dev_req,
  input  logic               step,
  input  logic               step_brk,
  input  logic               step_dsm,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_sel,
  input  logic [ADDR_W-1:0]  wr_data,
  output logic [IDX_W-1:0]   cur_seq,
  output logic [ADDR_W-1:0]  fetch_addr
);
  import mseq_pkg::*;

  localparam logic [IDX_W-1:0] BG_IDX = IDX_W'(NUM_SEQ - 1);

  step_t              st;
  sel_kind_e          kind;
  logic [IDX_W-1:0]   cur_q;
  logic [IDX_W-1:0]   nxt;
  logic [IDX_W-1:0]   win_idx;
  logic               win_any;
  logic [NUM_SEQ-1:0] clr;
  logic [NUM_SEQ-1:0] req_vec;
  logic [NUM_SEQ-1:0] req_nxt;

  assign st   = '{valid: step, brk: step_brk, dsm: step_dsm};
  assign kind = classify(st);

  // Retire the running sequence's request on dismiss.
  always_comb begin
    clr = '0;
    if (kind == SEL_RETIRE) clr[cur_q] = 1'b1;
  end

  mseq_req_latch #(.NUM_SEQ(NUM_SEQ)) u_req (
    .clk       (clk),
    .rst       (rst),
    .dev_req_i (dev_req),
    .clr_i     (clr),
    .req_o     (req_vec),
    .req_nxt_o (req_nxt)
  );

  mseq_prio_sel #(.NUM_SEQ(NUM_SEQ), .IDX_W(IDX_W)) u_sel (
    .req_i (req_nxt),
    .any_o (win_any),
    .idx_o (win_idx)
  );

  always_comb begin
    nxt = cur_q;
    if ((kind != SEL_KEEP) && win_any) nxt = win_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= BG_IDX;
    else     cur_q <= nxt;
  end

  mseq_pc_bank #(.NUM_SEQ(NUM_SEQ), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .cur_i     (cur_q),
    .nxt_i     (nxt),
    .step_i    (step),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_sel),
    .wr_data_i (wr_data),
    .fetch_o   (fetch_addr)
  );

  assign cur_seq = cur_q;

  // R5: without a break or dismiss the running sequence is kept.
  p_no_switch_r5: assert property (@(posedge clk) disable iff (rst)
    !(step && (step_brk || step_dsm)) |=> $stable(cur_q));

  // R4: a break can only move control to an equal or higher priority.
  p_break_up_r4: assert property (@(posedge clk) disable iff (rst)
    (step && step_brk && !step_dsm) |=> (cur_q <= $past(cur_q)));

  // R6: dismiss with no fresh request of the same device leaves that sequence.
  p_dismiss_leave_r6: assert property (@(posedge clk) disable iff (rst)
    (step && step_dsm && (cur_q != BG_IDX) && !dev_req[cur_q]) |=> (cur_q != $past(cur_q)));

  // R2: the running sequence always has a latched request.
  p_cur_pending_r2: assert property (@(posedge clk) disable iff (rst)
    req_vec[cur_q]);

endmodule

// File: tb/mseq_pc_sched_tb_top.sv
module mseq_pc_sched_tb_top;

  localparam int N  = 32;
  localparam int AW = 16;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  dev_req;
  logic          step, step_brk, step_dsm;
  logic          wr_en;
  logic [IW-1:0] wr_sel;
  logic [AW-1:0] wr_data;
  logic [IW-1:0] cur_seq;
  logic [AW-1:0] fetch_addr;

  always #4 clk = ~clk;

  mseq_pc_sched #(.NUM_SEQ(N), .ADDR_W(AW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst(rst), .dev_req(dev_req), .step(step), .step_brk(step_brk),
    .step_dsm(step_dsm), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_seq(cur_seq), .fetch_addr(fetch_addr)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // Reference model state
  logic [AW-1:0] m_pc [N];
  logic [N-1:0]  m_req;
  logic [N-1:0]  m_prev;
  int            m_cur;
  logic [AW-1:0] m_fetch;

  // Scoreboard queues
  int            q_cur  [$];
  logic [AW-1:0] q_addr [$];
  string         q_tag  [$];

  task automatic model_reset();
    m_req   = '0;
    m_req[N-1] = 1'b1;
    m_prev  = '0;
    m_cur   = N - 1;
    m_fetch = '0;
  endtask

  task automatic drive(input logic [N-1:0] rq, input bit s, input bit b, input bit d,
                       input bit we, input int wi, input logic [AW-1:0] wd, input string tag);
    logic [N-1:0]  rise;
    logic [N-1:0]  rn;
    logic [AW-1:0] live;
    int            nx;
    @(negedge clk);
    dev_req = rq; step = s; step_brk = b; step_dsm = d;
    wr_en = we; wr_sel = IW'(wi); wr_data = wd;
    rise = rq & ~m_prev;
    rise[N-1] = 1'b0;
    m_prev = rq;
    rn = m_req;
    if (s && d && m_cur != N-1) rn[m_cur] = 1'b0;
    rn = rn | rise;
    rn[N-1] = 1'b1;
    if (we && wi == m_cur) live = wd;
    else if (s)            live = m_fetch + 1'b1;
    else                   live = m_fetch;
    if (we && wi != m_cur) m_pc[wi] = wd;
    nx = m_cur;
    if (s && (b || d)) begin
      for (int i = N-1; i >= 0; i--) if (rn[i]) nx = i;
    end
    if (nx != m_cur) begin
      m_pc[m_cur] = live;
      m_fetch = m_pc[nx];
    end else begin
      m_fetch = live;
    end
    m_req = rn;
    m_cur = nx;
    q_cur.push_back(m_cur);
    q_addr.push_back(m_fetch);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive('0, 0, 0, 0, 0, 0, '0, tag);
  endtask

  function automatic logic [N-1:0] bit_of(input int k);
    logic [N-1:0] v;
    v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  // Monitor: compare one expected item per cycle, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_cur.size() > 0) begin
        int            ec;
        logic [AW-1:0] ea;
        string         tg;
        ec = q_cur.pop_front();
        ea = q_addr.pop_front();
        tg = q_tag.pop_front();
        n_checks++;
        if (int'(cur_seq) != ec || fetch_addr !== ea) begin
          n_fails++;
          $display("FAIL %s: cur_seq=%0d fetch_addr=%0d expected cur_seq=%0d fetch_addr=%0d",
                   tg, cur_seq, fetch_addr, ec, ea);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    dev_req = '0; step = 0; step_brk = 0; step_dsm = 0;
    wr_en = 0; wr_sel = '0; wr_data = '0;
    for (int i = 0; i < N; i++) m_pc[i] = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state visible
    idle("R1");

    // R8: load every counter; the last one is the running background sequence
    for (int i = 0; i < N; i++) drive('0, 0, 0, 0, 1, i, AW'(100 * i + 7), "R8");
    idle("R8");

    // R3: plain steps on the background sequence
    repeat (3) drive('0, 1, 0, 0, 0, 0, '0, "R3");
    idle("R3");

    // R5: request 5 pending, steps without break do not switch
    drive(bit_of(5), 1, 0, 0, 0, 0, '0, "R5");
    drive('0, 1, 0, 0, 0, 0, '0, "R5");
    drive('0, 1, 0, 0, 0, 0, '0, "R5");

    // R4: break switches to sequence 5 at its stored counter
    drive('0, 1, 1, 0, 0, 0, '0, "R4");
    drive('0, 1, 0, 0, 0, 0, '0, "R4");

    // R10: requests 2 and 9 rise during a break step; 2 wins
    drive(bit_of(2) | bit_of(9), 1, 1, 0, 0, 0, '0, "R10");
    drive('0, 1, 0, 0, 0, 0, '0, "R10");

    // R6: dismiss 2 returns to lower-priority 5
    drive('0, 1, 0, 1, 0, 0, '0, "R6");
    drive('0, 1, 0, 0, 0, 0, '0, "R7");

    // R9: dismiss 5 while its device raises a fresh request
    drive(bit_of(5), 1, 0, 1, 0, 0, '0, "R9");
    drive('0, 1, 0, 0, 0, 0, '0, "R9");

    // R6: dismiss 5 for real, then 9, back to background resume point (R7)
    drive('0, 1, 0, 1, 0, 0, '0, "R6");
    drive('0, 1, 0, 1, 0, 0, '0, "R7");
    drive('0, 1, 0, 0, 0, 0, '0, "R7");

    // R2: background line toggles, dismiss of background keeps it running
    drive(bit_of(N-1), 1, 0, 1, 0, 0, '0, "R2");
    drive('0, 1, 0, 1, 0, 0, '0, "R2");
    // R2: a line held high gives no second edge after a dismiss
    drive(bit_of(3), 1, 1, 0, 0, 0, '0, "R2");
    drive(bit_of(3), 1, 0, 1, 0, 0, '0, "R2");
    drive(bit_of(3), 1, 1, 0, 0, 0, '0, "R2");
    drive('0, 0, 0, 0, 0, 0, '0, "R2");

    // R8: load the running counter during a step
    drive('0, 1, 0, 0, 1, N-1, 16'h1234, "R8");
    drive('0, 1, 0, 0, 0, 0, '0, "R8");
    // R8: load the target of a switch in the same cycle
    drive(bit_of(4), 1, 0, 0, 0, 0, '0, "R8");
    drive('0, 1, 1, 0, 1, 4, 16'h0BEE, "R8");
    drive('0, 1, 0, 0, 0, 0, '0, "R8");

    // R6: break and dismiss together behave as dismiss
    drive(bit_of(1), 1, 0, 0, 0, 0, '0, "R6");
    drive('0, 1, 1, 1, 0, 0, '0, "R6");
    drive('0, 1, 1, 1, 0, 0, '0, "R6");
    drive('0, 1, 0, 0, 0, 0, '0, "R3");
    idle("R3");
    idle("R3");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule